// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Sequencer

This block writes a byte-wide one-time-programmable memory from a stream of source bytes. It sequences the device's supply and programming-voltage enables, and steps through every address in ascending order. At each address it asks the source for the byte to write. It then applies fixed-width program pulses, with a read-back after each one, until the stored word matches the source byte or the per-word pulse budget is spent. A cell that is still erased reads as all ones, so a source byte of all ones needs no pulse and is passed over.

Once every address has been written, the programming voltage is removed. The sequencer then fetches the whole image a second time and compares it against a plain read of each word. A word that will not take its data within the pulse budget ends the run at once. A mismatch in the final pass is recorded and the pass runs on to the end. In both cases the error flag is raised and the address of the first failing word is reported. A run is started with a one-cycle `start` and finishes with `done` held high and both rails off.

Top module: `otp_prog_seq`

## Requirements
- R1: When idle (`busy` low), chip enable, output enable and the source request are all inactive. A `start` seen while idle raises `busy` in the next cycle and clears `done`, `error` and `fail_addr`.
- R2: `vpp_en` is only ever high while `vcc_en` is high. The supply enable rises at least one cycle before the programming enable and falls at least one cycle after it.
- R3: A program pulse is `dev_ce_n` low with `dev_oe_n` high, lasting exactly PULSE_CYC cycles, with `dev_drive` and `vpp_en` high.
- R4: `dev_addr` and `dev_din` are driven, with `dev_drive` high, for at least SETTLE_CYC cycles before a pulse starts, and they do not change while the pulse lasts.
- R5: A verify read has `dev_ce_n` and `dev_oe_n` both low and `dev_drive` low. After each pulse, `dev_ce_n` returns high for one cycle before the read. `dev_q` is sampled at the end of the VERIFY_DLY-th cycle after `dev_ce_n` falls.
- R6: If the read-back after a pulse differs from the source byte, another pulse is applied to the same address, up to MAX_PULSES pulses per address. A word that matches after n pulses receives exactly n.
- R7: If a word still mismatches after MAX_PULSES pulses, the run stops. `error` is set, `fail_addr` holds that address, no later address is fetched or pulsed, and the rails are switched off before `done`.
- R8: A source byte equal to 8'hFF causes no program pulse at that address.
- R9: Source bytes are requested with `src_req` and `src_addr` and taken on the cycle `src_valid` is high. Addresses run 0, 1, ... up to 2^ADDR_W-1 in each pass.
- R10: After the last address, `vpp_en` is dropped and every address is fetched again and read with `vcc_en` high and `vpp_en` low. Any mismatch sets `error` and `fail_addr` to the first mismatching address, and the pass still completes.
- R11: At the end of a run, `done` goes high and stays high with `busy`, `vcc_en` and `vpp_en` low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle run request, taken while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| error | output | 1 | Pulse budget exceeded or final-pass mismatch |
| fail_addr | output | ADDR_W | First failing address |
| src_req | output | 1 | Source byte requested |
| src_addr | output | ADDR_W | Address of the requested byte |
| src_valid | input | 1 | Source byte present |
| src_data | input | 8 | Source byte |
| vcc_en | output | 1 | Device supply enable |
| vpp_en | output | 1 | Programming voltage enable |
| dev_addr | output | ADDR_W | Device address |
| dev_din | output | 8 | Data to be programmed |
| dev_drive | output | 1 | Data bus driven toward the device |
| dev_ce_n | output | 1 | Chip enable, active low |
| dev_oe_n | output | 1 | Output enable, active low |
| dev_q | input | 8 | Device read data |

## Verification
The bench contains a cell model. Its read data becomes valid only once chip and output enable have been low for VERIFY_DLY-1 earlier clock edges, and before that it returns a fixed garbage byte. A read sampled one cycle early therefore turns into a mismatch and an extra pulse, which the per-address pulse count exposes. The model measures each chip-enable low interval at the edges. It takes an interval as a pulse only when the interval is exactly PULSE_CYC edges long, and at the first pulse edge it checks that address and data have already been stable for SETTLE_CYC-1 edges. Run outcomes (`done`, `error`, `fail_addr`, the cell contents and the number of source fetches) are read on the falling edge after `done` rises, which is one cycle after the supply enable is seen low.

// File: rtl/otp_prog_pkg.sv
// Package: shared state encoding for the programming sequencer.
// Assumes: nothing beyond SystemVerilog-2017.
package otp_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR_UP,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_GAP,
        ST_VERIFY,
        ST_NEXT,
        ST_VPP_OFF,
        ST_FV_FETCH,
        ST_FV_READ,
        ST_PWR_DN
    } seq_state_t;

    // True for the states that need the programming voltage present.
    function automatic logic needs_vpp(input seq_state_t s);
        return (s == ST_PWR_UP) || (s == ST_FETCH) || (s == ST_SETUP) ||
               (s == ST_PULSE)  || (s == ST_GAP)   || (s == ST_VERIFY) ||
               (s == ST_NEXT);
    endfunction

endpackage

// File: rtl/otp_tick_timer.sv
// Module: down-counting interval timer.
// Loading a value N-1 makes `expired` high in the N-th cycle after the load.
// Assumes: the owner reloads it whenever it enters a timed state.
module otp_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/otp_rail_seq.sv
// Module: supply / programming-voltage enable sequencer.
// The supply follows rail_on, and is held up for as long as vpp is still up.
// Vpp comes up only once the supply is already up, and drops as soon as
// either request goes away.
// Assumes: the requests are plain levels from the controller.
module otp_rail_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_on,
    input  logic prog_pwr,
    output logic vcc_en,
    output logic vpp_en
);

    // Order the two enables so that vpp is always nested inside vcc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcc_en <= 1'b0;
            vpp_en <= 1'b0;
        end else begin
            vcc_en <= rail_on | vpp_en;
            vpp_en <= rail_on & prog_pwr & vcc_en;
        end
    end

    // R2
    vpp_inside_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_en |-> vcc_en);

    // R2
    vpp_rise_after_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_en) |-> $past(vcc_en));

    // R2
    vcc_fall_after_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> !$past(vpp_en));

endmodule

// File: rtl/otp_prog_seq.sv
// Module: programming sequencer top.
// Fetches each source byte in turn. A byte that is not 8'hFF gets
// settle/pulse/gap/verify loops until it reads back or the pulse budget
// runs out. The sequencer then drops vpp and runs a read-compare pass over
// the whole array.
// Assumes: the source answers every request eventually; PULSE_CYC,
// VERIFY_DLY and SETTLE_CYC are all at least 1.
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PULSE_CYC  = 25000,
    parameter int VERIFY_DLY = 4,
    parameter int SETTLE_CYC = 2,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              vcc_en,
    output logic              vpp_en,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [7:0]        dev_din,
    output logic              dev_drive,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    input  logic [7:0]        dev_q
);

    localparam int T_A    = (PULSE_CYC > VERIFY_DLY) ? PULSE_CYC : VERIFY_DLY;
    localparam int T_MAX  = (T_A > SETTLE_CYC) ? T_A : SETTLE_CYC;
    localparam int TMR_W  = $clog2(T_MAX + 1);
    localparam int PC_W   = $clog2(MAX_PULSES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_t        state, state_d;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        cur_data;
    logic [PC_W-1:0]   pulse_cnt;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              rail_on, prog_pwr;
    logic              at_last, rd_match;

    assign at_last  = (cur_addr == LAST_ADDR);
    assign rd_match = (dev_q == cur_data);

    otp_tick_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    otp_rail_seq u_rails (
        .clk      (clk),
        .rst_n    (rst_n),
        .rail_on  (rail_on),
        .prog_pwr (prog_pwr),
        .vcc_en   (vcc_en),
        .vpp_en   (vpp_en)
    );

    // Next-state decision for the whole program / verify sequence.
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE:     if (start) state_d = ST_PWR_UP;
            ST_PWR_UP:   if (vpp_en) state_d = ST_FETCH;
            ST_FETCH:    if (src_valid)
                             state_d = (src_data == 8'hFF) ? ST_NEXT : ST_SETUP;
            ST_SETUP:    if (tmr_zero) state_d = ST_PULSE;
            ST_PULSE:    if (tmr_zero) state_d = ST_GAP;
            ST_GAP:      state_d = ST_VERIFY;
            ST_VERIFY:   if (tmr_zero) begin
                             if (rd_match)                              state_d = ST_NEXT;
                             else if (pulse_cnt == PC_W'(MAX_PULSES))   state_d = ST_PWR_DN;
                             else                                       state_d = ST_SETUP;
                         end
            ST_NEXT:     state_d = at_last ? ST_VPP_OFF : ST_FETCH;
            ST_VPP_OFF:  if (!vpp_en) state_d = ST_FV_FETCH;
            ST_FV_FETCH: if (src_valid) state_d = ST_FV_READ;
            ST_FV_READ:  if (tmr_zero) state_d = at_last ? ST_PWR_DN : ST_FV_FETCH;
            ST_PWR_DN:   if (!vcc_en) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Reload the interval timer on entry to each timed state.
    always_comb begin
        tmr_load = (state_d != state);
        case (state_d)
            ST_SETUP:   tmr_val = TMR_W'(SETTLE_CYC - 1);
            ST_PULSE:   tmr_val = TMR_W'(PULSE_CYC - 1);
            ST_VERIFY,
            ST_FV_READ: tmr_val = TMR_W'(VERIFY_DLY - 1);
            default:    tmr_val = '0;
        endcase
    end

    // State, address walk, captured byte, pulse budget and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            cur_data  <= 8'hFF;
            pulse_cnt <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
            fail_addr <= '0;
        end else begin
            state <= state_d;
            case (state)
                ST_IDLE: if (start) begin
                    cur_addr  <= '0;
                    done      <= 1'b0;
                    error     <= 1'b0;
                    fail_addr <= '0;
                end
                ST_FETCH: if (src_valid) begin
                    cur_data  <= src_data;
                    pulse_cnt <= '0;
                end
                ST_SETUP: if (tmr_zero) pulse_cnt <= pulse_cnt + 1'b1;
                ST_VERIFY: if (tmr_zero && !rd_match &&
                               pulse_cnt == PC_W'(MAX_PULSES)) begin
                    error     <= 1'b1;
                    fail_addr <= cur_addr;
                end
                ST_NEXT: cur_addr <= cur_addr + 1'b1;
                ST_FV_FETCH: if (src_valid) cur_data <= src_data;
                ST_FV_READ: if (tmr_zero) begin
                    if (!rd_match && !error) begin
                        error     <= 1'b1;
                        fail_addr <= cur_addr;
                    end
                    if (!at_last) cur_addr <= cur_addr + 1'b1;
                end
                ST_PWR_DN: if (!vcc_en) done <= 1'b1;
                default: ;
            endcase
        end
    end

    // Decode device, source and rail controls from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        src_req   = (state == ST_FETCH) || (state == ST_FV_FETCH);
        src_addr  = cur_addr;
        dev_addr  = cur_addr;
        dev_din   = cur_data;
        dev_drive = (state == ST_SETUP) || (state == ST_PULSE);
        dev_ce_n  = !((state == ST_PULSE) || (state == ST_VERIFY) ||
                      (state == ST_FV_READ));
        dev_oe_n  = !((state == ST_VERIFY) || (state == ST_FV_READ));
        rail_on   = (state != ST_IDLE) && (state != ST_PWR_DN);
        prog_pwr  = needs_vpp(state);
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_ce_n && dev_oe_n && !src_req));

    // R3
    pulse_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && dev_oe_n) |-> (dev_drive && vpp_en));

    // R4
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && dev_oe_n && !$past(dev_ce_n)) |->
            ($stable(dev_addr) && $stable(dev_din)));

    // R5
    read_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> (!dev_ce_n && !dev_drive));

    // R6
    pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PC_W'(MAX_PULSES));

    // R10
    final_pass_no_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FV_READ) |-> (vcc_en && !vpp_en));

    // R11
    done_rails_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !vcc_en && !vpp_en));

endmodule

// File: tb/otp_prog_seq_bench.sv
module otp_prog_seq_bench;

    localparam int ADDR_W     = 5;
    localparam int N          = 1 << ADDR_W;
    localparam int PULSE_CYC  = 6;
    localparam int VERIFY_DLY = 3;
    localparam int SETTLE_CYC = 2;
    localparam int MAX_PULSES = 25;
    localparam int WDOG       = 40000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              busy, done, error;
    logic [ADDR_W-1:0] fail_addr;
    logic              src_req;
    logic [ADDR_W-1:0] src_addr;
    logic              src_valid = 1'b0;
    logic [7:0]        src_data = 8'h00;
    logic              vcc_en, vpp_en;
    logic [ADDR_W-1:0] dev_addr;
    logic [7:0]        dev_din;
    logic              dev_drive, dev_ce_n, dev_oe_n;
    logic [7:0]        dev_q;

    always #2 clk = ~clk;

    otp_prog_seq #(
        .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .VERIFY_DLY(VERIFY_DLY),
        .SETTLE_CYC(SETTLE_CYC), .MAX_PULSES(MAX_PULSES)
    ) u_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .error(error), .fail_addr(fail_addr), .src_req(src_req),
        .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
        .vcc_en(vcc_en), .vpp_en(vpp_en), .dev_addr(dev_addr),
        .dev_din(dev_din), .dev_drive(dev_drive), .dev_ce_n(dev_ce_n),
        .dev_oe_n(dev_oe_n), .dev_q(dev_q)
    );

    // Stimulus tables, written only by the main initial block.
    logic [7:0] image [N];
    int         need  [N];
    bit         corrupt [N];
    logic       model_clr = 1'b0;

    // Model state, written only by the model process.
    logic [7:0]        mem    [N];
    int                pulses [N];
    int                hits   [N];
    int                low_len, rcnt, stab, fetch_cnt, exp_fetch;
    int                v_pwr, v_width, v_setup, v_read, v_order;
    logic [ADDR_W-1:0] p_addr, last_addr;
    logic [7:0]        p_data, last_din;

    int n_chk = 0;
    int n_err = 0;

    // Cell model: the read value is valid only after VERIFY_DLY-1 earlier read edges.
    assign dev_q = (!dev_ce_n && !dev_oe_n && rcnt >= VERIFY_DLY - 1)
                 ? (mem[dev_addr] ^ ((corrupt[dev_addr] && !vpp_en) ? 8'h01 : 8'h00))
                 : 8'h5A;

    always @(posedge clk) begin
        if (model_clr) begin
            for (int i = 0; i < N; i++) begin
                mem[i]    <= 8'hFF;
                pulses[i] <= 0;
                hits[i]   <= 0;
            end
            low_len <= 0; rcnt <= 0; stab <= 0; fetch_cnt <= 0; exp_fetch <= 0;
            v_pwr <= 0; v_width <= 0; v_setup <= 0; v_read <= 0; v_order <= 0;
            last_addr <= '0; last_din <= '0; p_addr <= '0; p_data <= '0;
        end else begin
            if (vpp_en && !vcc_en) v_pwr <= v_pwr + 1;
            rcnt <= (!dev_ce_n && !dev_oe_n) ? rcnt + 1 : 0;
            if (!dev_oe_n && dev_drive) v_read <= v_read + 1;
            if (dev_drive && dev_addr == last_addr && dev_din == last_din)
                stab <= stab + 1;
            else
                stab <= 0;
            last_addr <= dev_addr;
            last_din  <= dev_din;
            if (!dev_ce_n && dev_oe_n) begin
                if (low_len == 0) begin
                    if (stab < SETTLE_CYC - 1) v_setup <= v_setup + 1;
                    p_addr <= dev_addr;
                    p_data <= dev_din;
                end else if (dev_addr != p_addr || dev_din != p_data) begin
                    v_setup <= v_setup + 1;
                end
                low_len <= low_len + 1;
            end else if (low_len != 0) begin
                if (low_len != PULSE_CYC) v_width <= v_width + 1;
                pulses[p_addr] <= pulses[p_addr] + 1;
                if (vpp_en && vcc_en && low_len == PULSE_CYC) begin
                    if (hits[p_addr] + 1 >= need[p_addr])
                        mem[p_addr] <= mem[p_addr] & p_data;
                    hits[p_addr] <= hits[p_addr] + 1;
                end
                low_len <= 0;
            end
            if (src_req && src_valid) begin
                if (int'(src_addr) != exp_fetch) v_order <= v_order + 1;
                exp_fetch <= (exp_fetch + 1) % N;
                fetch_cnt <= fetch_cnt + 1;
            end
        end
    end

    // Source: answers each request after 0..2 cycles, for exactly one cycle.
    int lat = 0;
    always @(negedge clk) begin
        if (src_req && !src_valid) begin
            if (lat == 0) begin
                src_valid <= 1'b1;
                src_data  <= image[src_addr];
                lat       <= int'($urandom % 3);
            end else begin
                lat <= lat - 1;
            end
        end else begin
            src_valid <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Expected pulse count at one address; stop_at is the address where a run aborts.
    function automatic int exp_pulses(input int a, input int stop_at);
        if (a > stop_at) return 0;
        if (image[a] == 8'hFF) return 0;
        return (need[a] > MAX_PULSES) ? MAX_PULSES : need[a];
    endfunction

    function automatic logic [7:0] exp_cell(input int a, input int stop_at);
        if (a > stop_at || need[a] > MAX_PULSES) return 8'hFF;
        return image[a];
    endfunction

    task automatic run_case(input bit exp_err, input int exp_fail, input int stop_at,
                            input int exp_fetches);
        int cyc;
        @(negedge clk) model_clr = 1'b1;
        @(negedge clk) model_clr = 1'b0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R1: busy due one cycle after start
        check(busy === 1'b1 && done === 1'b0 && error === 1'b0, "R1 start",
              {busy, done, error}, 3'b100);
        cyc = 0;
        while (done !== 1'b1 && cyc < WDOG) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < WDOG, "watchdog", cyc, WDOG);
        // R11
        check(!busy && !vcc_en && !vpp_en, "R11 rails off at done",
              {busy, vcc_en, vpp_en}, 0);
        // R7 / R10
        check(error === exp_err, "R7/R10 error flag", error, exp_err);
        if (exp_err)
            check(int'(fail_addr) == exp_fail, "R7/R10 fail_addr", fail_addr, exp_fail);
        // R9
        check(fetch_cnt == exp_fetches, "R9 fetch count", fetch_cnt, exp_fetches);
        check(v_order == 0, "R9 fetch order", v_order, 0);
        // R2
        check(v_pwr == 0, "R2 vpp without vcc", v_pwr, 0);
        // R3
        check(v_width == 0, "R3 pulse width", v_width, 0);
        // R4
        check(v_setup == 0, "R4 setup/hold", v_setup, 0);
        // R5
        check(v_read == 0, "R5 bus released on read", v_read, 0);
        for (int a = 0; a < N; a++) begin
            // R6 R8 R7: pulses per word
            check(pulses[a] == exp_pulses(a, stop_at), "R6/R8 pulses per word",
                  pulses[a], exp_pulses(a, stop_at));
            check(mem[a] == exp_cell(a, stop_at), "R6 cell content",
                  mem[a], exp_cell(a, stop_at));
        end
        // R11: done held
        repeat (5) @(negedge clk);
        check(done === 1'b1 && !busy, "R11 done held", {done, busy}, 2'b10);
    endtask

    initial begin
        void'($urandom(32'd7411));
        for (int a = 0; a < N; a++) begin
            image[a] = 8'hFF; need[a] = 1; corrupt[a] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !error && !vcc_en && !vpp_en && dev_ce_n && dev_oe_n && !src_req,
              "R1 reset state",
              {busy, done, error, vcc_en, vpp_en, dev_ce_n, dev_oe_n, src_req}, 8'b00000110);
        rst_n = 1'b1;
        @(negedge clk);

        // Random image with some erased bytes, random pulse needs.
        for (int a = 0; a < N; a++) begin
            image[a] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
            if (image[a] == 8'hFF && ($urandom % 2 == 0)) image[a] = 8'h3C;
            need[a]  = 1 + int'($urandom % 4);
        end
        run_case(1'b0, 0, N, 2 * N);

        // Directed: word needing exactly the full budget, first word erased, last word zero.
        image[0] = 8'hFF; need[7] = MAX_PULSES; image[7] = 8'h81; image[N-1] = 8'h00;
        run_case(1'b0, 0, N, 2 * N);

        // R7: a word that needs one pulse more than the budget.
        need[7] = 2; image[12] = 8'h42; need[12] = MAX_PULSES + 1;
        run_case(1'b1, 12, 12, 13);

        // R10: two words that read back wrong once vpp is off.
        need[12] = 3; corrupt[20] = 1'b1; corrupt[9] = 1'b1; image[9] = 8'h77;
        run_case(1'b1, 9, N, 2 * N);

        // R8: fully erased image needs no pulses at all.
        for (int a = 0; a < N; a++) begin
            image[a] = 8'hFF; corrupt[a] = 1'b0;
        end
        run_case(1'b0, 0, N, 2 * N);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule